// File: doc/BRIEF.md
# Supply Threshold Event Controller

This block watches a comparator level that is already synchronized to the clock. The level reads 1 while the supply sits below a threshold. The level can pass through a sampled three-tap digital filter, or it can bypass the filter and go straight through. Bypass is the mode to use when the event has to wake a device that has its clocks stopped. When the filtered level crosses the threshold in the programmed direction, the block sets a sticky passage flag. If events are enabled, it also raises either a one-cycle interrupt pulse or a held reset request.

Software sees one 8-bit control register. In it software enables events, chooses filter or bypass, picks the sampling divider, chooses interrupt or reset, and picks the crossing direction. It reads the passage flag and clears that flag by writing 0. A separate reset-status output records that the monitor requested a reset. This output is held by the power-on reset domain, so it survives the system reset that the request causes. The filter is fed by a free-running low-speed tick input, and a selectable power-of-two divider thins that tick into sampling ticks.

Top module: `vmon_evt_ctrl`

## Requirements
- R1: After reset, `cfg_rdata_o` reads 0, and `irq_o`, `rst_req_o` and `rst_stat_o` are 0.
- R2: The control layout is: bit0 event enable, bit1 filter bypass (1 = bypass), bit2 passage flag, bits[4:3] sample divider select, bit5 mode (0 = interrupt, 1 = reset request), bits[7:6] direction. A write of 0 to bit2 clears the flag. A write of 1 to bit2 leaves it unchanged. A crossing in the same cycle as a clear wins over the clear.
- R3: With bit1 = 1, a comparator change is treated as a crossing directly, with no sampling.
- R4: With bit1 = 0, the filtered level changes only when three consecutive sampling ticks all see the new comparator value. Shorter runs are ignored.
- R5: After the filter becomes active (bypass off and both monitor enables high), no crossing is reported until three samples have been taken. The level those samples establish is not itself a crossing.
- R6: A divider select of k makes one sampling tick every 2^k low-speed ticks.
- R7: Direction 00 selects the supply rising above the threshold (comparator 1 to 0). Direction 01 selects the supply falling to or below it (comparator 0 to 1). Directions 10 and 11 select either crossing.
- R8: A crossing in the selected direction sets the passage flag even while bit0 is 0. Such a crossing never produces an interrupt later, when bit0 is set.
- R9: No crossing is detected unless both `det_en_i` and `mon_en_i` are 1. No event is produced unless bit0 is also 1.
- R10: In interrupt mode, each qualifying crossing gives `irq_o` high for exactly one cycle, one cycle after the crossing is seen.
- R11: In reset mode, `rst_req_o` rises on a qualifying crossing only when the direction is 01. It stays high until `rst_ack_i`. Any other direction leaves both `rst_req_o` and `irq_o` low.
- R12: `rst_stat_o` sets together with a reset request. It survives `rst_ni` and is cleared only by `rst_stat_clr_i` or `por_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset for the reset-status flag |
| osc_tick_i | input | 1 | One-cycle tick from the low-speed oscillator |
| cmp_below_i | input | 1 | Synchronized comparator level, 1 = supply below threshold |
| det_en_i | input | 1 | Detector enable |
| mon_en_i | input | 1 | Global monitor enable |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control register write data |
| cfg_rdata_o | output | 8 | Control register read value |
| rst_ack_i | input | 1 | Clears a pending reset request |
| rst_stat_clr_i | input | 1 | Clears the reset-status flag |
| irq_o | output | 1 | One-cycle interrupt request |
| rst_req_o | output | 1 | Held reset request |
| rst_stat_o | output | 1 | Monitor-caused reset status |

## Verification
The bench builds the block with its defaults: a divider step of one bit per select value and a three-tap filter. Every divider select from /1 to /8 is therefore reachable in a few dozen low-speed ticks. At divide-by-four, any twelve consecutive ticks hold exactly three sampling points, which lets the bench assert the filter's three-sample boundary without knowing the divider phase. A small filter depth also keeps glitch runs of one and two samples short enough to aim at directly.

// File: rtl/vmon_pkg.sv
package vmon_pkg;

  typedef enum logic [1:0] {
    DIR_RISE = 2'b00,
    DIR_FALL = 2'b01,
    DIR_ANYA = 2'b10,
    DIR_ANYB = 2'b11
  } vmon_dir_e;

  typedef struct packed {
    vmon_dir_e  dir;
    logic       rst_mode;
    logic [1:0] clk_sel;
    logic       pass_flag;
    logic       flt_bypass;
    logic       evt_en;
  } vmon_cfg_t;

  localparam int unsigned CFG_W = $bits(vmon_cfg_t);

endpackage

// File: rtl/vmon_tick_div.sv
module vmon_tick_div #(
  parameter int unsigned STEP  = 1,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             smp_tick_o
);
  localparam int unsigned CNT_W = ((1 << SEL_W) - 1) * STEP;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int b = 0; b < CNT_W; b++) begin
      if (b < int'(sel_i) * int'(STEP)) mask[b] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (osc_tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign smp_tick_o = osc_tick_i && ((cnt_q & mask) == mask);
endmodule

// File: rtl/vmon_dig_filter.sv
module vmon_dig_filter #(
  parameter int unsigned TAPS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic smp_tick_i,
  input  logic din_i,
  output logic lvl_o,
  output logic valid_o
);
  localparam int unsigned CW = $clog2(TAPS + 1);

  logic [TAPS-2:0] sh_q;
  logic [TAPS-1:0] win;
  logic [CW-1:0]   cnt_q;
  logic            flt_q;
  logic            full;

  assign win  = {sh_q, din_i};
  assign full = (cnt_q == CW'(TAPS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else if (!run_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else if (smp_tick_i) begin
      sh_q <= win[TAPS-2:0];
      if (!full) cnt_q <= cnt_q + 1'b1;
      if (&win)       flt_q <= 1'b1;
      else if (~|win) flt_q <= 1'b0;
    end
  end

  assign lvl_o   = flt_q;
  assign valid_o = run_i && full;
endmodule

// File: rtl/vmon_edge_det.sv
module vmon_edge_det
  import vmon_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  logic      valid_i,
  input  vmon_dir_e dir_i,
  output logic      hit_o
);
  logic lvl_q, vld_q;
  logic both, sup_fall, sup_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
      vld_q <= valid_i;
    end
  end

  assign both     = valid_i && vld_q;
  assign sup_fall = both && !lvl_q && lvl_i;
  assign sup_rise = both && lvl_q && !lvl_i;

  always_comb begin
    case (dir_i)
      DIR_RISE: hit_o = sup_rise;
      DIR_FALL: hit_o = sup_fall;
      default:  hit_o = sup_rise || sup_fall;
    endcase
  end
endmodule

// File: rtl/vmon_evt_out.sv
module vmon_evt_out
  import vmon_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      por_ni,
  input  logic      fire_i,
  input  logic      rst_mode_i,
  input  vmon_dir_e dir_i,
  input  logic      rst_ack_i,
  input  logic      stat_clr_i,
  output logic      irq_o,
  output logic      rst_req_o,
  output logic      rst_stat_o
);
  logic irq_q, req_q, stat_q, req_set;

  // reset requests only for the falling-supply selection
  assign req_set = fire_i && rst_mode_i && (dir_i == DIR_FALL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      irq_q <= fire_i && !rst_mode_i;
      req_q <= req_set || (req_q && !rst_ack_i);
    end
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) stat_q <= 1'b0;
    else         stat_q <= req_set || (stat_q && !stat_clr_i);
  end

  assign irq_o      = irq_q;
  assign rst_req_o  = req_q;
  assign rst_stat_o = stat_q;
endmodule

// File: rtl/vmon_evt_ctrl.sv
module vmon_evt_ctrl
  import vmon_pkg::*;
#(
  parameter int unsigned DIV_STEP = 1,
  parameter int unsigned FLT_TAPS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             osc_tick_i,
  input  logic             cmp_below_i,
  input  logic             det_en_i,
  input  logic             mon_en_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic             rst_ack_i,
  input  logic             rst_stat_clr_i,
  output logic             irq_o,
  output logic             rst_req_o,
  output logic             rst_stat_o
);
  vmon_cfg_t cfg_q, wr;
  logic active, flt_run, smp_tick;
  logic flt_lvl, flt_vld, lvl, vld, hit, fire;

  assign wr      = vmon_cfg_t'(cfg_wdata_i);
  assign active  = det_en_i && mon_en_i;
  assign flt_run = active && !cfg_q.flt_bypass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      if (cfg_we_i) begin
        cfg_q.dir        <= wr.dir;
        cfg_q.rst_mode   <= wr.rst_mode;
        cfg_q.clk_sel    <= wr.clk_sel;
        cfg_q.flt_bypass <= wr.flt_bypass;
        cfg_q.evt_en     <= wr.evt_en;
        cfg_q.pass_flag  <= hit || (cfg_q.pass_flag && wr.pass_flag);
      end else begin
        cfg_q.pass_flag  <= hit || cfg_q.pass_flag;
      end
    end
  end

  vmon_tick_div #(.STEP(DIV_STEP), .SEL_W(2)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_tick_i (osc_tick_i),
    .sel_i      (cfg_q.clk_sel),
    .smp_tick_o (smp_tick)
  );

  vmon_dig_filter #(.TAPS(FLT_TAPS)) u_flt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (flt_run),
    .smp_tick_i (smp_tick),
    .din_i      (cmp_below_i),
    .lvl_o      (flt_lvl),
    .valid_o    (flt_vld)
  );

  assign lvl = cfg_q.flt_bypass ? cmp_below_i : flt_lvl;
  assign vld = cfg_q.flt_bypass ? active      : flt_vld;

  vmon_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (lvl),
    .valid_i (vld),
    .dir_i   (cfg_q.dir),
    .hit_o   (hit)
  );

  assign fire = hit && cfg_q.evt_en;

  vmon_evt_out u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_ni     (por_ni),
    .fire_i     (fire),
    .rst_mode_i (cfg_q.rst_mode),
    .dir_i      (cfg_q.dir),
    .rst_ack_i  (rst_ack_i),
    .stat_clr_i (rst_stat_clr_i),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o),
    .rst_stat_o (rst_stat_o)
  );

  assign cfg_rdata_o = cfg_q;
endmodule

// File: rtl/vmon_evt_ctrl_chk.sv
module vmon_evt_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_ni,
  input logic       det_en_i,
  input logic       mon_en_i,
  input logic       rst_ack_i,
  input logic       cfg_en_i,
  input logic       cfg_flag_i,
  input logic       cfg_mode_i,
  input logic [1:0] cfg_dir_i,
  input logic       irq_o,
  input logic       rst_req_o,
  input logic       rst_stat_o
);
  AST_IRQ_INT_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(cfg_en_i && !cfg_mode_i)); // R10
  AST_IRQ_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cfg_flag_i); // R8
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(det_en_i && mon_en_i)); // R9
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && !rst_ack_i) |=> rst_req_o); // R11
  AST_REQ_FALL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(cfg_mode_i && cfg_dir_i == 2'b01 && cfg_en_i)); // R11
  AST_REQ_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $rose(rst_req_o) |-> rst_stat_o); // R12
endmodule

bind vmon_evt_ctrl vmon_evt_ctrl_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .por_ni     (por_ni),
  .det_en_i   (det_en_i),
  .mon_en_i   (mon_en_i),
  .rst_ack_i  (rst_ack_i),
  .cfg_en_i   (cfg_rdata_o[0]),
  .cfg_flag_i (cfg_rdata_o[2]),
  .cfg_mode_i (cfg_rdata_o[5]),
  .cfg_dir_i  (cfg_rdata_o[7:6]),
  .irq_o      (irq_o),
  .rst_req_o  (rst_req_o),
  .rst_stat_o (rst_stat_o)
);

// File: tb/vmon_evt_ctrl_tb_top.sv
`timescale 1ns/1ps
module vmon_evt_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0, por_ni = 1'b0;
  logic       osc_tick_i = 1'b0, cmp_below_i = 1'b0;
  logic       det_en_i = 1'b1, mon_en_i = 1'b1;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] cfg_rdata_o;
  logic       rst_ack_i = 1'b0, rst_stat_clr_i = 1'b0;
  logic       irq_o, rst_req_o, rst_stat_o;

  int checks = 0, errors = 0, irq_cnt = 0, base = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  vmon_evt_ctrl dut_i (.*);

  always @(negedge clk_i) if (irq_o) irq_cnt++;

  // {dir[1:0], cmp start, cmp end, expected irq count, expected flag}
  localparam int NV = 8;
  localparam logic [5:0] VEC [NV] = '{
    {2'b00, 1'b1, 1'b0, 1'b1, 1'b1},
    {2'b00, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'b01, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'b10, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'b10, 1'b1, 1'b0, 1'b1, 1'b1},
    {2'b11, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'b11, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  function automatic logic [7:0] cf(logic [1:0] dir, logic mode, logic [1:0] sel,
                                    logic flag, logic byp, logic en);
    return {dir, mode, sel, flag, byp, en};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk_i); cfg_we_i = 1'b1; cfg_wdata_i = d;
    @(negedge clk_i); cfg_we_i = 1'b0;
  endtask

  task automatic osc(input int n);
    repeat (n) begin
      @(negedge clk_i); osc_tick_i = 1'b1;
      @(negedge clk_i); osc_tick_i = 1'b0;
    end
  endtask

  initial begin
    cyc(3);
    por_ni = 1'b1; rst_ni = 1'b1;
    cyc(2);
    chk("R1 cfg", cfg_rdata_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 req", rst_req_o, 0);
    chk("R1 stat", rst_stat_o, 0);

    // R3 R7 R10: bypass direction table
    for (int i = 0; i < NV; i++) begin
      cmp_below_i = VEC[i][3];
      wr(cf(VEC[i][5:4], 1'b0, 2'b00, 1'b0, 1'b1, 1'b1));
      cyc(3);
      wr(cf(VEC[i][5:4], 1'b0, 2'b00, 1'b0, 1'b1, 1'b1));
      base = irq_cnt;
      cyc(2);
      cmp_below_i = VEC[i][2];
      cyc(4);
      chk("R7 R10 irq count", irq_cnt - base, int'(VEC[i][1]));
      chk("R3 R7 flag", cfg_rdata_o[2], int'(VEC[i][0]));
    end

    // R5: filter start-up with comparator already high
    cmp_below_i = 1'b1; cyc(3);
    wr(cf(2'b01, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1));
    base = irq_cnt;
    osc(3); cyc(3);
    chk("R5 no flag at start-up", cfg_rdata_o[2], 0);
    chk("R5 no irq at start-up", irq_cnt - base, 0);

    // R4 R7: rising crossing filtered but not selected, then glitch, then real
    cmp_below_i = 1'b0; osc(3); cyc(3);
    chk("R7 unselected direction", cfg_rdata_o[2], 0);
    cmp_below_i = 1'b1; osc(2);
    cmp_below_i = 1'b0; osc(3); cyc(3);
    chk("R4 two-sample glitch", cfg_rdata_o[2], 0);
    cmp_below_i = 1'b1; osc(2); cyc(3);
    chk("R4 two samples", cfg_rdata_o[2], 0);
    osc(1); cyc(3);
    chk("R4 third sample flag", cfg_rdata_o[2], 1);
    chk("R4 third sample irq", irq_cnt - base, 1);

    // R6: divide by four
    wr(cf(2'b01, 1'b0, 2'b10, 1'b0, 1'b0, 1'b1));
    base = irq_cnt;
    cmp_below_i = 1'b0; osc(12); cyc(3);
    cmp_below_i = 1'b1; osc(8); cyc(3);
    chk("R6 eight ticks", cfg_rdata_o[2], 0);
    osc(4); cyc(3);
    chk("R6 twelve ticks", cfg_rdata_o[2], 1);
    chk("R6 irq", irq_cnt - base, 1);

    // R8 R2: events disabled, flag still latches
    cmp_below_i = 1'b0;
    wr(cf(2'b01, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0));
    cyc(3);
    wr(cf(2'b01, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0));
    base = irq_cnt;
    cmp_below_i = 1'b1; cyc(4);
    chk("R8 flag while disabled", cfg_rdata_o[2], 1);
    wr(cf(2'b01, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1));
    cyc(4);
    chk("R8 no late irq", irq_cnt - base, 0);
    chk("R2 write 1 keeps flag", cfg_rdata_o[2], 1);
    wr(cf(2'b01, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1));
    cyc(1);
    chk("R2 write 0 clears flag", cfg_rdata_o[2], 0);
    wr(cf(2'b01, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1));
    cyc(1);
    chk("R2 write 1 does not set", cfg_rdata_o[2], 0);

    // R9: detector or global enable off
    cmp_below_i = 1'b0; cyc(3);
    det_en_i = 1'b0; cyc(2);
    cmp_below_i = 1'b1; cyc(4);
    chk("R9 det off flag", cfg_rdata_o[2], 0);
    chk("R9 det off irq", irq_cnt - base, 0);
    det_en_i = 1'b1; cmp_below_i = 1'b0; cyc(3);
    mon_en_i = 1'b0; cyc(2);
    cmp_below_i = 1'b1; cyc(4);
    chk("R9 mon off flag", cfg_rdata_o[2], 0);
    mon_en_i = 1'b1; cyc(3);
    chk("R9 re-enable no event", irq_cnt - base, 0);

    // R11: reset mode with rising direction does nothing
    cmp_below_i = 1'b1; cyc(2);
    wr(cf(2'b00, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1));
    cyc(3);
    cmp_below_i = 1'b0; cyc(4);
    chk("R11 rising flag", cfg_rdata_o[2], 1);
    chk("R11 rising no req", rst_req_o, 0);
    chk("R11 rising no irq", irq_cnt - base, 0);

    // R11 R12: falling in reset mode
    wr(cf(2'b01, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1));
    cyc(3);
    cmp_below_i = 1'b1; cyc(3);
    chk("R11 req raised", rst_req_o, 1);
    chk("R12 stat set", rst_stat_o, 1);
    chk("R11 no irq in reset mode", irq_cnt - base, 0);
    cyc(6);
    chk("R11 req held", rst_req_o, 1);
    rst_ack_i = 1'b1; cyc(1); rst_ack_i = 1'b0; cyc(1);
    chk("R11 req acked", rst_req_o, 0);
    rst_ni = 1'b0; cyc(2); rst_ni = 1'b1; cyc(2);
    chk("R12 stat survives reset", rst_stat_o, 1);
    chk("R1 cfg after reset", cfg_rdata_o, 0);
    rst_stat_clr_i = 1'b1; cyc(1); rst_stat_clr_i = 1'b0; cyc(1);
    chk("R12 stat cleared", rst_stat_o, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule